// File: doc/BRIEF.md
# Duplicate-Tag Lookup Directory

This block keeps a shadow copy of the tags held by every private first-level cache on a chip whose cache hierarchy is exclusive. In that hierarchy the shared second-level cache works as a victim store. It never keeps a line that some first-level cache already holds, and its lines are only Modified, Exclusive or Invalid. Requests that arrive on chip therefore need one central place that says which private caches hold a line, so that a data request can be sent to one of them. No copy of the data is made for this.

The directory has as many sets as a single first-level cache. Its associativity is the first-level associativity multiplied by the number of first-level caches. Way `w` of cache `k` always maps to directory slot `k*L1_ASSOC + w`, so an update writes straight into its slot and never searches for one. Each slot records whether its cache holds the line. The per-cache presence vector is formed from those records. No owner is tracked: a data request goes to the lowest-numbered cache whose presence bit is set.

The lookup port takes a line address and answers one cycle later with a hit flag, the presence vector and the chosen source. The update port carries fills (install) and evictions (remove) from the caches. An update and a lookup to the same set in the same cycle are ordered so that the update comes first.

Top module: `dtag_directory`

## Requirements
- R1: After a synchronous active-low reset every slot is empty, `rsp_valid`, `rsp_hit`, `rsp_present`, `rsp_src` and `rm_err` are 0, and any lookup misses.
- R2: After an install of address A by cache k, a lookup of A raised in cycle n gives `rsp_valid=1`, `rsp_hit=1` and bit k of `rsp_present` set in cycle n+1.
- R3: Bit k of `rsp_present` is 1 exactly when some slot of cache k in the indexed set is valid and holds A's tag. Several bits can be set at once.
- R4: On a hit, `rsp_src` is the lowest k whose presence bit is set. On a miss it is 0.
- R5: A remove of A by cache k at the way holding A clears that slot. The other caches' presence for A is unchanged, and A misses once no cache holds it.
- R6: Way w of cache k always uses slot k*L1_ASSOC+w. An install into an occupied slot replaces its tag, so the old line is no longer reported for cache k.
- R7: When an update and a lookup target the same set in the same cycle, the lookup result reflects the array after the update.
- R8: A remove whose slot is empty or holds a different tag leaves the array unchanged and sets `rm_err`. `rm_err` stays 1 until reset.
- R9: The set index is the low log2(L1_SETS) bits of the address and the tag is the rest. The same tag under a different index misses.
- R10: `rsp_valid` is 1 exactly in the cycle after `lk_req` was 1. In a cycle without a response, `rsp_hit`, `rsp_present` and `rsp_src` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Line address to look up |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | At least one cache holds the line |
| rsp_present | output | NUM_L1 | Presence bit per first-level cache |
| rsp_src | output | log2(NUM_L1) | Cache chosen to supply data |
| upd_req | input | 1 | Update request |
| upd_l1 | input | log2(NUM_L1) | Cache issuing the update |
| upd_way | input | log2(L1_ASSOC) | Way within that cache |
| upd_addr | input | ADDR_W | Line address being filled or evicted |
| upd_install | input | 1 | 1 = install (fill), 0 = remove (eviction) |
| rm_err | output | 1 | Sticky flag: a remove named a line not present |

## Verification
Two functions can fall in the same cycle: an update and a lookup to the same set. The bench provokes this by driving an install and a lookup of the same address together, and later a remove and a lookup of that address together. It judges the result by requiring a hit in the first case and a miss in the second, which proves the lookup saw the post-update state. The checker adds a property that any same-cycle install of the looked-up address must show up in the next response as a hit, with the installing cache's bit set.

// File: rtl/dtag_pkg.sv
// Package: shared definitions for the duplicate-tag directory.
// Assumes: nothing beyond IEEE 1800-2017.
package dtag_pkg;

    // Meaning of the update-port operation bit.
    typedef enum logic {
        UPD_REMOVE  = 1'b0,
        UPD_INSTALL = 1'b1
    } upd_op_e;

endpackage

// File: rtl/dtag_array.sv
// Module: dtag_array
// Holds a valid bit and a tag for every (set, slot). It applies one update
// per cycle and flags removes of lines that are not present (sticky).
// It also gives a read view of one set in which a same-cycle update to that
// set is already applied, so a lookup sees the post-update state.
// Assumes: WAYS >= 2; the upd_slot values used are below WAYS.
module dtag_array #(
    parameter int WAYS    = 8,
    parameter int SETS    = 16,
    parameter int TAG_W   = 8,
    localparam int SLOT_W = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_req,
    input  logic [SLOT_W-1:0]          upd_slot,
    input  logic [SET_W-1:0]           upd_set,
    input  logic [TAG_W-1:0]           upd_tag,
    input  dtag_pkg::upd_op_e          upd_op,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic                       rm_err
);
    import dtag_pkg::*;

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic                      rm_match;
    logic                      is_install;

    // Decode the operation and see whether a remove names a stored line.
    always_comb begin
        is_install = (upd_op == UPD_INSTALL);
        rm_match   = vld_q[upd_set][upd_slot] && (tag_q[upd_set][upd_slot] == upd_tag);
    end

    // Valid bits: set on install, cleared on a remove that matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (upd_req) begin
            if (is_install) begin
                vld_q[upd_set][upd_slot] <= 1'b1;
            end else if (rm_match) begin
                vld_q[upd_set][upd_slot] <= 1'b0;
            end
        end
    end

    // Tag storage: written on install only; no reset needed behind valid bits.
    always_ff @(posedge clk) begin
        if (upd_req && is_install) begin
            tag_q[upd_set][upd_slot] <= upd_tag;
        end
    end

    // Sticky error: a remove that finds no matching line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm_err <= 1'b0;
        end else if (upd_req && !is_install && !rm_match) begin
            rm_err <= 1'b1;
        end
    end

    // Read view per slot, with the same-cycle update forwarded in.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        logic hit_slot;
        // Apply the pending update to this slot when it targets the read set.
        always_comb begin
            hit_slot    = upd_req && (upd_set == rd_set) && (upd_slot == SLOT_W'(w));
            rd_valid[w] = vld_q[rd_set][w];
            rd_tag[w]   = tag_q[rd_set][w];
            if (hit_slot) begin
                if (is_install) begin
                    rd_valid[w] = 1'b1;
                    rd_tag[w]   = upd_tag;
                end else if (rm_match) begin
                    rd_valid[w] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dtag_match.sv
// Module: dtag_match
// Compares one tag against every slot of a set and folds the per-slot
// matches into one presence bit per first-level cache. Cache k owns the
// slots k*L1_ASSOC to k*L1_ASSOC+L1_ASSOC-1.
// Assumes: the slots come in the fixed cache-major order.
module dtag_match #(
    parameter int NUM_L1   = 4,
    parameter int L1_ASSOC = 2,
    parameter int TAG_W    = 8,
    localparam int WAYS    = NUM_L1 * L1_ASSOC
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic [NUM_L1-1:0]          presence
);
    for (genvar k = 0; k < NUM_L1; k++) begin : g_l1
        logic [L1_ASSOC-1:0] way_hit;
        for (genvar w = 0; w < L1_ASSOC; w++) begin : g_way
            // One comparator per slot of this cache.
            assign way_hit[w] = way_valid[k*L1_ASSOC + w] &&
                                (way_tag[k*L1_ASSOC + w] == cmp_tag);
        end
        // The cache holds the line if any of its ways matches.
        assign presence[k] = |way_hit;
    end
endmodule

// File: rtl/dtag_pick.sv
// Module: dtag_pick
// Chooses the data source: the lowest-numbered cache whose presence bit is
// set. Reports a hit when any bit is set; the index is 0 on a miss.
// Assumes: NUM_L1 >= 2.
module dtag_pick #(
    parameter int NUM_L1  = 4,
    localparam int ID_W   = $clog2(NUM_L1)
) (
    input  logic [NUM_L1-1:0] presence,
    output logic              any_hit,
    output logic [ID_W-1:0]   src
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        any_hit = |presence;
        src     = '0;
        for (int k = NUM_L1 - 1; k >= 0; k--) begin
            if (presence[k]) begin
                src = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/dtag_directory.sv
// Module: dtag_directory (top)
// Central duplicate-tag directory for an exclusive cache hierarchy. It takes
// fills and evictions from the first-level caches on the update port. On the
// lookup port it answers one cycle later with hit, presence vector and the
// chosen source cache.
// Assumes: NUM_L1, L1_ASSOC and L1_SETS are powers of two and at least 2;
// ADDR_W is greater than log2(L1_SETS).
module dtag_directory #(
    parameter int NUM_L1   = 4,
    parameter int L1_ASSOC = 2,
    parameter int L1_SETS  = 16,
    parameter int ADDR_W   = 12,
    localparam int ID_W    = $clog2(NUM_L1),
    localparam int WAY_W   = $clog2(L1_ASSOC),
    localparam int SET_W   = $clog2(L1_SETS),
    localparam int TAG_W   = ADDR_W - SET_W,
    localparam int WAYS    = NUM_L1 * L1_ASSOC,
    localparam int SLOT_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NUM_L1-1:0] rsp_present,
    output logic [ID_W-1:0]   rsp_src,
    input  logic              upd_req,
    input  logic [ID_W-1:0]   upd_l1,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_install,
    output logic              rm_err
);
    import dtag_pkg::*;

    logic [SLOT_W-1:0]          upd_slot;
    upd_op_e                    upd_op;
    logic [WAYS-1:0]            rd_valid;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [NUM_L1-1:0]          pres_c;
    logic                       hit_c;
    logic [ID_W-1:0]            src_c;

    // Fixed slot placement: cache-major, way-minor.
    always_comb begin
        upd_slot = SLOT_W'(upd_l1) * SLOT_W'(L1_ASSOC) + SLOT_W'(upd_way);
        upd_op   = upd_install ? UPD_INSTALL : UPD_REMOVE;
    end

    dtag_array #(
        .WAYS  (WAYS),
        .SETS  (L1_SETS),
        .TAG_W (TAG_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_req  (upd_req),
        .upd_slot (upd_slot),
        .upd_set  (upd_addr[SET_W-1:0]),
        .upd_tag  (upd_addr[ADDR_W-1:SET_W]),
        .upd_op   (upd_op),
        .rd_set   (lk_addr[SET_W-1:0]),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rm_err   (rm_err)
    );

    dtag_match #(
        .NUM_L1   (NUM_L1),
        .L1_ASSOC (L1_ASSOC),
        .TAG_W    (TAG_W)
    ) u_match (
        .way_valid (rd_valid),
        .way_tag   (rd_tag),
        .cmp_tag   (lk_addr[ADDR_W-1:SET_W]),
        .presence  (pres_c)
    );

    dtag_pick #(
        .NUM_L1 (NUM_L1)
    ) u_pick (
        .presence (pres_c),
        .any_hit  (hit_c),
        .src      (src_c)
    );

    // Response register: one-cycle lookup latency, zeroed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_present <= '0;
            rsp_src     <= '0;
        end else begin
            rsp_valid   <= lk_req;
            rsp_hit     <= lk_req && hit_c;
            rsp_present <= lk_req ? pres_c : '0;
            rsp_src     <= lk_req ? src_c : '0;
        end
    end

endmodule

// File: rtl/dtag_directory_chk.sv
// Module: dtag_directory_chk
// Property checker for dtag_directory, attached through bind below.
// Assumes: connected to the top-level ports with the same parameters.
module dtag_directory_chk #(
    parameter int NUM_L1   = 4,
    parameter int L1_ASSOC = 2,
    parameter int ADDR_W   = 12,
    localparam int ID_W    = $clog2(NUM_L1),
    localparam int WAY_W   = $clog2(L1_ASSOC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [NUM_L1-1:0] rsp_present,
    input logic [ID_W-1:0]   rsp_src,
    input logic              upd_req,
    input logic [ID_W-1:0]   upd_l1,
    input logic [WAY_W-1:0]  upd_way,
    input logic              upd_install,
    input logic [ADDR_W-1:0] upd_addr,
    input logic              rm_err
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit && rsp_present == '0 && rsp_src == '0)); // R10
    AST_SRC_IS_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_present[rsp_src]); // R4
    AST_SRC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ((rsp_present & ((NUM_L1'(1) << rsp_src) - NUM_L1'(1))) == '0)); // R4
    AST_MISS_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_present == '0 && rsp_src == '0)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rm_err |=> rm_err); // R8
    AST_ERR_FROM_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && upd_install) |=> (rm_err == $past(rm_err))); // R8
    AST_SAME_CYCLE_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && upd_req && upd_install && lk_addr == upd_addr)
        |=> (rsp_hit && rsp_present[$past(upd_l1)])); // R7
endmodule

bind dtag_directory dtag_directory_chk #(
    .NUM_L1   (NUM_L1),
    .L1_ASSOC (L1_ASSOC),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_req      (lk_req),
    .lk_addr     (lk_addr),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_present (rsp_present),
    .rsp_src     (rsp_src),
    .upd_req     (upd_req),
    .upd_l1      (upd_l1),
    .upd_way     (upd_way),
    .upd_install (upd_install),
    .upd_addr    (upd_addr),
    .rm_err      (rm_err)
);

// File: tb/test_dtag_directory.sv
`timescale 1ns/1ps
module test_dtag_directory;
    localparam int NUM_L1   = 4;
    localparam int L1_ASSOC = 2;
    localparam int L1_SETS  = 16;
    localparam int ADDR_W   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rsp_valid, rsp_hit, rm_err;
    logic [NUM_L1-1:0] rsp_present;
    logic [1:0]        rsp_src;
    logic              upd_req = 1'b0;
    logic [1:0]        upd_l1 = '0;
    logic              upd_way = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              upd_install = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Addresses: low 4 bits are the set index, upper 8 bits the tag.
    localparam logic [ADDR_W-1:0] A_ADDR = 12'h3A5;
    localparam logic [ADDR_W-1:0] B_ADDR = 12'h7C5;
    localparam logic [ADDR_W-1:0] C_ADDR = 12'h114;
    localparam logic [ADDR_W-1:0] A_OTHER_SET = 12'h3A6;
    localparam logic [ADDR_W-1:0] D_ADDR = 12'h555;
    localparam logic [ADDR_W-1:0] E_ADDR = 12'h0F5;

    always #4 clk = ~clk;

    dtag_directory #(
        .NUM_L1(NUM_L1), .L1_ASSOC(L1_ASSOC), .L1_SETS(L1_SETS), .ADDR_W(ADDR_W)
    ) i_dtag_directory (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_present(rsp_present),
        .rsp_src(rsp_src), .upd_req(upd_req), .upd_l1(upd_l1), .upd_way(upd_way),
        .upd_addr(upd_addr), .upd_install(upd_install), .rm_err(rm_err)
    );

    task automatic check(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Drive one update for a cycle; returns at the next falling edge.
    task automatic update(int l1, int way, logic [ADDR_W-1:0] addr, bit inst);
        upd_req = 1'b1; upd_l1 = 2'(l1); upd_way = 1'(way);
        upd_addr = addr; upd_install = inst;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    // Lookup and check the response sampled one cycle later.
    task automatic look(string rq, logic [ADDR_W-1:0] addr, bit hit, int pres, int src);
        lk_req = 1'b1; lk_addr = addr;
        @(negedge clk);
        lk_req = 1'b0;
        check(rq, "rsp_valid", int'(rsp_valid), 1);
        check(rq, "rsp_hit", int'(rsp_hit), int'(hit));
        check(rq, "rsp_present", int'(rsp_present), pres);
        check(rq, "rsp_src", int'(rsp_src), src);
    endtask

    task automatic t_reset_state();
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check("R1", "rm_err after reset", int'(rm_err), 0);
        look("R1", A_ADDR, 1'b0, 0, 0);
        @(negedge clk);
        check("R10", "rsp_valid idle", int'(rsp_valid), 0);
        check("R10", "rsp_present idle", int'(rsp_present), 0);
    endtask

    task automatic t_install_single();
        update(2, 1, A_ADDR, 1'b1);
        look("R2", A_ADDR, 1'b1, 4'b0100, 2);
        @(negedge clk);
        check("R10", "rsp_hit idle after hit", int'(rsp_hit), 0);
    endtask

    task automatic t_multi_sharers();
        update(3, 0, A_ADDR, 1'b1);
        update(1, 0, A_ADDR, 1'b1);
        look("R3", A_ADDR, 1'b1, 4'b1110, 1);
        update(1, 0, A_ADDR, 1'b0);
        look("R5", A_ADDR, 1'b1, 4'b1100, 2);
        check("R5", "rm_err after good remove", int'(rm_err), 0);
    endtask

    task automatic t_slot_overwrite();
        update(3, 0, B_ADDR, 1'b1);
        look("R6", A_ADDR, 1'b1, 4'b0100, 2);
        look("R6", B_ADDR, 1'b1, 4'b1000, 3);
    endtask

    task automatic t_index_isolation();
        look("R9", A_OTHER_SET, 1'b0, 0, 0);
    endtask

    task automatic t_same_cycle();
        upd_req = 1'b1; upd_l1 = 2'd0; upd_way = 1'b0; upd_addr = C_ADDR; upd_install = 1'b1;
        lk_req = 1'b1; lk_addr = C_ADDR;
        @(negedge clk);
        upd_req = 1'b0; lk_req = 1'b0;
        check("R7", "hit on same-cycle install", int'(rsp_hit), 1);
        check("R7", "present on same-cycle install", int'(rsp_present), 4'b0001);
        check("R7", "src on same-cycle install", int'(rsp_src), 0);
        upd_req = 1'b1; upd_install = 1'b0;
        lk_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0; lk_req = 1'b0;
        check("R7", "hit on same-cycle remove", int'(rsp_hit), 0);
        check("R7", "present on same-cycle remove", int'(rsp_present), 0);
        check("R5", "rm_err after matching remove", int'(rm_err), 0);
    endtask

    task automatic t_bad_remove();
        update(1, 1, D_ADDR, 1'b0);
        check("R8", "rm_err after remove of empty slot", int'(rm_err), 1);
        update(2, 1, E_ADDR, 1'b0);
        look("R8", A_ADDR, 1'b1, 4'b0100, 2);
        update(0, 1, C_ADDR, 1'b1);
        check("R8", "rm_err stays set", int'(rm_err), 1);
        look("R8", B_ADDR, 1'b1, 4'b1000, 3);
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "rm_err cleared by reset", int'(rm_err), 0);
        look("R1", A_ADDR, 1'b0, 0, 0);
        look("R1", C_ADDR, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_install_single();
        t_multi_sharers();
        t_slot_overwrite();
        t_index_isolation();
        t_same_cycle();
        t_bad_remove();
        t_reset_clears();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule